// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM Model

This block is a synthesizable model of a synchronous static memory with a register on every input and a register on the data output. Each access starts from one of two address strobes: a processor strobe and a controller strobe. Three chip selects gate the start of an access, and the two strobes respond to them differently. Writes use a global write control or a byte-write enable with per-lane selects over four byte lanes. A two-bit wrapping counter steps through a burst in either linear or interleaved order. An asynchronous output enable gates the data driver.

The model is used as a behavioural stand-in for an external burst memory inside a larger simulation or prototype. The tri-state bus is split into `dq_i`, `dq_o` and a drive flag `dq_oe`. The controller state machine has three states:

- IDLE: deselected; nothing is driven.
- READ: the output stage holds read data and may drive the bus.
- WRITE: the output stage holds a write, so the bus is not driven.

The transitions are:

- start-read: from any state, to READ.
- start-write: from any state, through the controller strobe, to WRITE.
- continue-read and continue-write: from READ or WRITE, when no strobe is given. The write controls choose READ or WRITE.
- drop: from READ or WRITE to IDLE, when a valid strobe arrives with a chip select inactive.
- hold: IDLE stays IDLE when no valid strobe arrives.

Top module: `burst_sram`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, `dq_oe` is 0 and the controller is in IDLE. An idle cycle (no strobe) does not leave IDLE.
- R2: A read start is presented at rising edge N. The data of its address is then on `dq_o` with `dq_oe`=1 from edge N+1, provided `out_en_n` is low.
- R3: Read starts on consecutive edges each return their own word on consecutive cycles, with no idle cycle between them.
- R4: A write starts when `ctl_strobe_n`=0, all chip selects are active and `wr_all_n` or `wr_byte_en_n` is low. It stores `dq_i` from the same edge to `addr`.
- R5: With `wr_all_n`=0, all four lanes are written whatever `lane_sel_n` holds.
- R6: With `wr_all_n`=1 and `wr_byte_en_n`=0, lane i (`dq_i` bits 8i+7..8i) is written only when `lane_sel_n[i]`=0.
- R7: A start by `cpu_strobe_n`=0 with all chip selects active is always a read, even if the write controls are low. In a following cycle with no strobe, low write controls write the current burst address.
- R8: `cpu_strobe_n` has no effect while `sel1_n`=1. The access in progress continues unchanged.
- R9: A valid strobe with any chip select inactive (`sel1_n`=1, `sel2`=0 or `sel3_n`=1) deselects the block.
- R10: In a cycle with no strobe, `burst_adv_n`=0 advances the 2-bit counter k. The upper address bits stay fixed. The low bits are (s+k) mod 4 when `lin_mode`=1, and s xor k when `lin_mode`=0, where s is the start's low bits. The counter wraps after four steps.
- R11: A deselect is presented at edge N. The bus keeps driving the previous read data until edge N+1 and is undriven after it.
- R12: When an access starts from IDLE, the bus stays undriven during its first cycle (edge N to N+1). It is driven from N+1.
- R13: `out_en_n`=1 clears `dq_oe` at once, without a clock edge, and leaves the pipeline contents unchanged.
- R14: The bus is not driven in a cycle whose output stage holds a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lin_mode | input | 1 | Burst order strap: 1 linear, 0 interleaved |
| addr | input | AW | Word address |
| cpu_strobe_n | input | 1 | Processor address strobe, active low |
| ctl_strobe_n | input | 1 | Controller address strobe, active low |
| burst_adv_n | input | 1 | Burst advance, active low |
| sel1_n | input | 1 | First chip select, active low |
| sel2 | input | 1 | Second chip select, active high |
| sel3_n | input | 1 | Third chip select, active low |
| wr_all_n | input | 1 | Global write, active low |
| wr_byte_en_n | input | 1 | Byte-write enable, active low |
| lane_sel_n | input | NB | Per-lane write selects, active low |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| dq_i | input | NB*BW | Write data |
| dq_o | output | NB*BW | Read data from the output register |
| dq_oe | output | 1 | Data driver enable |

## Verification
A deselect and a new access can fall in the same cycle. While the deselect is being decided, the output register still drives the previous read data and the next read start is already being registered. The bench provokes this by presenting a deselect and then a read on the next edge. It judges the bus cycle by cycle: old word driven, then undriven, then the new word. Its expected values come from a bench-side copy of the memory, updated by the byte-lane rules.

// File: rtl/bsram_pkg.sv
package bsram_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD   = 2'd1,
        ST_WR   = 2'd2
    } acc_state_t;

    typedef enum logic [1:0] {
        CMD_HOLD = 2'd0,
        CMD_DROP = 2'd1,
        CMD_CPU  = 2'd2,
        CMD_CTL  = 2'd3
    } acc_cmd_t;

    // low two address bits of burst step 'stp' from start offset 'first'
    function automatic logic [1:0] burst_offset(input logic [1:0] first,
                                                input logic [1:0] stp,
                                                input logic       linear);
        if (linear)
            return first + stp;
        else
            return first ^ stp;
    endfunction

endpackage

// File: rtl/bsram_inreg.sv
module bsram_inreg #(
    parameter int AW = 6,
    parameter int NB = 4,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          cpu_strobe_n,
    input  logic          ctl_strobe_n,
    input  logic          burst_adv_n,
    input  logic          sel1_n,
    input  logic          sel2,
    input  logic          sel3_n,
    input  logic          wr_all_n,
    input  logic          wr_byte_en_n,
    input  logic [NB-1:0] lane_sel_n,
    input  logic [DW-1:0] dq_i,
    output logic [AW-1:0] addr_q,
    output logic          cpu_strobe_n_q,
    output logic          ctl_strobe_n_q,
    output logic          burst_adv_n_q,
    output logic          sel1_n_q,
    output logic          sel2_q,
    output logic          sel3_n_q,
    output logic          wr_all_n_q,
    output logic          wr_byte_en_n_q,
    output logic [NB-1:0] lane_sel_n_q,
    output logic [DW-1:0] dq_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q         <= '0;
            cpu_strobe_n_q <= 1'b1;
            ctl_strobe_n_q <= 1'b1;
            burst_adv_n_q  <= 1'b1;
            sel1_n_q       <= 1'b1;
            sel2_q         <= 1'b0;
            sel3_n_q       <= 1'b1;
            wr_all_n_q     <= 1'b1;
            wr_byte_en_n_q <= 1'b1;
            lane_sel_n_q   <= '1;
            dq_q           <= '0;
        end else begin
            addr_q         <= addr;
            cpu_strobe_n_q <= cpu_strobe_n;
            ctl_strobe_n_q <= ctl_strobe_n;
            burst_adv_n_q  <= burst_adv_n;
            sel1_n_q       <= sel1_n;
            sel2_q         <= sel2;
            sel3_n_q       <= sel3_n;
            wr_all_n_q     <= wr_all_n;
            wr_byte_en_n_q <= wr_byte_en_n;
            lane_sel_n_q   <= lane_sel_n;
            dq_q           <= dq_i;
        end
    end

endmodule

// File: rtl/bsram_ctrl.sv
module bsram_ctrl
    import bsram_pkg::*;
#(
    parameter int NB = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_strobe_n,
    input  logic          ctl_strobe_n,
    input  logic          burst_adv_n,
    input  logic          sel1_n,
    input  logic          sel2,
    input  logic          sel3_n,
    input  logic          wr_all_n,
    input  logic          wr_byte_en_n,
    input  logic [NB-1:0] lane_sel_n,
    output logic          load,
    output logic          advance,
    output logic          wr_en,
    output logic [NB-1:0] lane_wr,
    output logic          capture
);

    acc_state_t st_q;
    acc_state_t st_d;
    acc_cmd_t   cmd;
    logic       sel_ok;
    logic       cpu_ok;
    logic       wr_req;

    // command decode from the registered inputs
    always_comb begin
        sel_ok = !sel1_n && sel2 && !sel3_n;
        cpu_ok = !cpu_strobe_n && !sel1_n;
        wr_req = !wr_all_n || !wr_byte_en_n;
        if (cpu_ok)
            cmd = sel_ok ? CMD_CPU : CMD_DROP;
        else if (!ctl_strobe_n)
            cmd = sel_ok ? CMD_CTL : CMD_DROP;
        else
            cmd = CMD_HOLD;
    end

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                unique case (cmd)
                    CMD_CPU:  st_d = ST_RD;
                    CMD_CTL:  st_d = wr_req ? ST_WR : ST_RD;
                    default:  st_d = ST_IDLE;
                endcase
            end
            ST_RD, ST_WR: begin
                unique case (cmd)
                    CMD_DROP: st_d = ST_IDLE;
                    CMD_CPU:  st_d = ST_RD;
                    default:  st_d = wr_req ? ST_WR : ST_RD;
                endcase
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= ST_IDLE;
        else
            st_q <= st_d;
    end

    // outputs
    always_comb begin
        load    = (cmd == CMD_CPU) || (cmd == CMD_CTL);
        advance = (cmd == CMD_HOLD) && (st_q != ST_IDLE) && !burst_adv_n;
        wr_en   = (st_d == ST_WR);
        capture = (st_d == ST_RD);
        if (!wr_all_n)
            lane_wr = '1;
        else if (!wr_byte_en_n)
            lane_wr = ~lane_sel_n;
        else
            lane_wr = '0;
    end

endmodule

// File: rtl/bsram_burst.sv
module bsram_burst
    import bsram_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          linear,
    input  logic          load,
    input  logic          advance,
    input  logic [AW-1:0] start_addr,
    output logic [AW-1:0] acc_addr
);

    localparam int UW = AW - 2;

    logic [AW-1:0] base_q;
    logic [1:0]    cnt_q;
    logic [1:0]    cnt_use;

    always_comb begin
        cnt_use = advance ? 2'(cnt_q + 2'd1) : cnt_q;
        if (load)
            acc_addr = start_addr;
        else
            acc_addr = {base_q[AW-1 -: UW], burst_offset(base_q[1:0], cnt_use, linear)};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= 2'd0;
        end else if (load) begin
            base_q <= start_addr;
            cnt_q  <= 2'd0;
        end else begin
            cnt_q  <= cnt_use;
        end
    end

endmodule

// File: rtl/bsram_lanes.sv
module bsram_lanes #(
    parameter int AW = 6,
    parameter int NB = 4,
    parameter int BW = 8
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [NB-1:0]    lane_wr,
    input  logic [AW-1:0]    addr,
    input  logic [NB*BW-1:0] wdata,
    output logic [NB*BW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    for (genvar g = 0; g < NB; g++) begin : g_lane
        logic [BW-1:0] cells [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && lane_wr[g])
                cells[addr] <= wdata[g*BW +: BW];
        end

        assign rdata[g*BW +: BW] = cells[addr];
    end

endmodule

// File: rtl/burst_sram.sv
module burst_sram #(
    parameter  int AW = 6,
    parameter  int NB = 4,
    parameter  int BW = 8,
    localparam int DW = NB * BW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lin_mode,
    input  logic [AW-1:0] addr,
    input  logic          cpu_strobe_n,
    input  logic          ctl_strobe_n,
    input  logic          burst_adv_n,
    input  logic          sel1_n,
    input  logic          sel2,
    input  logic          sel3_n,
    input  logic          wr_all_n,
    input  logic          wr_byte_en_n,
    input  logic [NB-1:0] lane_sel_n,
    input  logic          out_en_n,
    input  logic [DW-1:0] dq_i,
    output logic [DW-1:0] dq_o,
    output logic          dq_oe
);

    logic [AW-1:0] addr_q;
    logic          cpu_q, ctl_q, adv_q, s1_q, s2_q, s3_q, wa_q, wb_q;
    logic [NB-1:0] ls_q;
    logic [DW-1:0] din_q;
    logic          load, advance, wr_en, capture;
    logic [NB-1:0] lane_wr;
    logic [AW-1:0] acc_addr;
    logic [DW-1:0] rdata;
    logic [DW-1:0] data_q;
    logic          drive_q;

    bsram_inreg #(.AW(AW), .NB(NB), .DW(DW)) u_inreg (
        .clk(clk), .rst_n(rst_n), .addr(addr),
        .cpu_strobe_n(cpu_strobe_n), .ctl_strobe_n(ctl_strobe_n),
        .burst_adv_n(burst_adv_n), .sel1_n(sel1_n), .sel2(sel2), .sel3_n(sel3_n),
        .wr_all_n(wr_all_n), .wr_byte_en_n(wr_byte_en_n), .lane_sel_n(lane_sel_n),
        .dq_i(dq_i),
        .addr_q(addr_q), .cpu_strobe_n_q(cpu_q), .ctl_strobe_n_q(ctl_q),
        .burst_adv_n_q(adv_q), .sel1_n_q(s1_q), .sel2_q(s2_q), .sel3_n_q(s3_q),
        .wr_all_n_q(wa_q), .wr_byte_en_n_q(wb_q), .lane_sel_n_q(ls_q), .dq_q(din_q)
    );

    bsram_ctrl #(.NB(NB)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cpu_strobe_n(cpu_q), .ctl_strobe_n(ctl_q), .burst_adv_n(adv_q),
        .sel1_n(s1_q), .sel2(s2_q), .sel3_n(s3_q),
        .wr_all_n(wa_q), .wr_byte_en_n(wb_q), .lane_sel_n(ls_q),
        .load(load), .advance(advance), .wr_en(wr_en), .lane_wr(lane_wr),
        .capture(capture)
    );

    bsram_burst #(.AW(AW)) u_burst (
        .clk(clk), .rst_n(rst_n), .linear(lin_mode), .load(load),
        .advance(advance), .start_addr(addr_q), .acc_addr(acc_addr)
    );

    bsram_lanes #(.AW(AW), .NB(NB), .BW(BW)) u_lanes (
        .clk(clk), .wr_en(wr_en), .lane_wr(lane_wr), .addr(acc_addr),
        .wdata(din_q), .rdata(rdata)
    );

    // output register stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drive_q <= 1'b0;
            data_q  <= '0;
        end else begin
            drive_q <= capture;
            if (capture)
                data_q <= rdata;
        end
    end

    assign dq_o  = data_q;
    assign dq_oe = drive_q && !out_en_n;

endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk (
    input logic clk,
    input logic rst_n,
    input logic cpu_strobe_n,
    input logic ctl_strobe_n,
    input logic sel1_n,
    input logic sel2,
    input logic sel3_n,
    input logic wr_all_n,
    input logic wr_byte_en_n,
    input logic out_en_n,
    input logic dq_oe
);

    logic sel_ok, cpu_ok, ctl_try, drop, rd_go, wr_go;
    logic in_rst_q;

    assign sel_ok  = !sel1_n && sel2 && !sel3_n;
    assign cpu_ok  = !cpu_strobe_n && !sel1_n;
    assign ctl_try = !cpu_ok && !ctl_strobe_n;
    assign drop    = (cpu_ok || ctl_try) && !sel_ok;
    assign rd_go   = sel_ok && (cpu_ok || (ctl_try && wr_all_n && wr_byte_en_n));
    assign wr_go   = sel_ok && ctl_try && (!wr_all_n || !wr_byte_en_n);

    always_ff @(posedge clk) in_rst_q <= !rst_n;

    // R1
    always @(posedge clk) begin
        if (in_rst_q)
            reset_quiet_chk: assert (!dq_oe);
    end

    // R13
    oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_en_n |-> !dq_oe);

    // R2
    read_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_go |-> ##2 (out_en_n || dq_oe));

    // R11
    late_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drop |-> ##2 !dq_oe);

    // R14
    write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_go |-> ##2 !dq_oe);

    // R12
    reselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drop ##1 rd_go |-> ##1 !dq_oe);

endmodule

bind burst_sram burst_sram_chk chk_i (
    .clk(clk), .rst_n(rst_n), .cpu_strobe_n(cpu_strobe_n),
    .ctl_strobe_n(ctl_strobe_n), .sel1_n(sel1_n), .sel2(sel2), .sel3_n(sel3_n),
    .wr_all_n(wr_all_n), .wr_byte_en_n(wr_byte_en_n), .out_en_n(out_en_n),
    .dq_oe(dq_oe)
);

// File: tb/burst_sram_test.sv
`timescale 1ns/1ps
module burst_sram_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lin_mode = 1'b1;
    logic [5:0]  addr = '0;
    logic        cpu_strobe_n = 1'b1, ctl_strobe_n = 1'b1, burst_adv_n = 1'b1;
    logic        sel1_n = 1'b0, sel2 = 1'b1, sel3_n = 1'b0;
    logic        wr_all_n = 1'b1, wr_byte_en_n = 1'b1;
    logic [3:0]  lane_sel_n = '1;
    logic        out_en_n = 1'b0;
    logic [31:0] dq_i = '0;
    logic [31:0] dq_o;
    logic        dq_oe;

    int n_checks = 0;
    int n_fail = 0;
    logic [31:0] model [64];

    always #2.5 clk = ~clk;

    burst_sram uut (
        .clk(clk), .rst_n(rst_n), .lin_mode(lin_mode), .addr(addr),
        .cpu_strobe_n(cpu_strobe_n), .ctl_strobe_n(ctl_strobe_n),
        .burst_adv_n(burst_adv_n), .sel1_n(sel1_n), .sel2(sel2), .sel3_n(sel3_n),
        .wr_all_n(wr_all_n), .wr_byte_en_n(wr_byte_en_n), .lane_sel_n(lane_sel_n),
        .out_en_n(out_en_n), .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe)
    );

    function automatic logic [31:0] pattern(input int a);
        return {8'(a), 8'(~a), 8'(a * 3 + 1), 8'(a ^ 8'h5A)};
    endfunction

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic set_idle();
        cpu_strobe_n = 1'b1; ctl_strobe_n = 1'b1; burst_adv_n = 1'b1;
        sel1_n = 1'b0; sel2 = 1'b1; sel3_n = 1'b0;
        wr_all_n = 1'b1; wr_byte_en_n = 1'b1; lane_sel_n = '1;
    endtask

    task automatic set_ctl_rd(input int a);
        set_idle();
        ctl_strobe_n = 1'b0;
        addr = 6'(a);
    endtask

    task automatic set_ctl_wr(input int a, input logic [31:0] d, input logic all_n,
                              input logic byte_n, input logic [3:0] ls_n);
        set_idle();
        ctl_strobe_n = 1'b0;
        addr = 6'(a);
        dq_i = d;
        wr_all_n = all_n;
        wr_byte_en_n = byte_n;
        lane_sel_n = ls_n;
    endtask

    task automatic set_deselect();
        set_idle();
        ctl_strobe_n = 1'b0;
        sel2 = 1'b0;
    endtask

    task automatic check_bus(input string req, input logic exp_oe, input logic [31:0] exp_d);
        n_checks++;
        if (dq_oe !== exp_oe || (exp_oe && dq_o !== exp_d)) begin
            n_fail++;
            $display("FAIL %s: got oe=%0b data=%h, expected oe=%0b data=%h",
                     req, dq_oe, dq_o, exp_oe, exp_d);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got running, expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        set_idle();
        repeat (3) step();
        check_bus("R1 in reset", 1'b0, '0);
        rst_n = 1'b1;
        step();
        check_bus("R1 after reset", 1'b0, '0);
        step();
        check_bus("R1 idle keeps IDLE", 1'b0, '0);

        // R4: controller-strobe global writes to every address
        for (int a = 0; a < 64; a++) begin
            set_ctl_wr(a, pattern(a), 1'b0, 1'b1, 4'hF);
            model[a] = pattern(a);
            step();
        end
        set_idle();
        step();
        check_bus("R14 after writes", 1'b0, '0);

        // R3: back-to-back reads over all addresses
        for (int a = 0; a < 64; a++) begin
            set_ctl_rd(a);
            step();
            if (a > 0) check_bus("R3/R4 pipelined read", 1'b1, model[a-1]);
        end
        set_idle();
        step();
        check_bus("R3/R4 last read", 1'b1, model[63]);

        // R2: single read latency
        set_ctl_rd(7);
        step();
        check_bus("R2 old word until edge N+1", 1'b1, model[63]);
        set_idle();
        step();
        check_bus("R2 word at edge N+1", 1'b1, model[7]);

        // R6 / R14: every lane-select mask
        for (int m = 0; m < 16; m++) begin
            logic [31:0] d;
            d = {4{8'(m * 17 + 3)}} ^ 32'h0F1E2D3C;
            set_ctl_wr(9, d, 1'b1, 1'b0, 4'(m));
            for (int i = 0; i < 4; i++)
                if (!m[i]) model[9][i*8 +: 8] = d[i*8 +: 8];
            step();
            set_ctl_rd(9);
            step();
            check_bus("R14 write not driven", 1'b0, '0);
            set_idle();
            step();
            check_bus("R6 byte lanes", 1'b1, model[9]);
        end

        // R5: global write overrides lane selects
        set_ctl_wr(10, 32'hCAFE_F00D, 1'b0, 1'b0, 4'hF);
        model[10] = 32'hCAFE_F00D;
        step();
        set_ctl_rd(10);
        step();
        set_idle();
        step();
        check_bus("R5 global write", 1'b1, model[10]);

        // R7: processor-strobe start is a read, then continuation write
        set_idle();
        cpu_strobe_n = 1'b0; addr = 6'd12; wr_all_n = 1'b0; dq_i = 32'h1234_5678;
        step();
        set_idle();
        step();
        check_bus("R7 start is read", 1'b1, model[12]);
        set_idle();
        wr_all_n = 1'b0; dq_i = 32'h89AB_CDEF;
        model[12] = 32'h89AB_CDEF;
        step();
        set_idle();
        step();
        check_bus("R7 continuation write quiet", 1'b0, '0);
        step();
        check_bus("R7 continuation write data", 1'b1, model[12]);

        // R8: processor strobe ignored while sel1_n high
        set_ctl_rd(20);
        step();
        set_idle();
        cpu_strobe_n = 1'b0; sel1_n = 1'b1; addr = 6'd33;
        step();
        set_idle();
        step();
        check_bus("R8 ignored strobe", 1'b1, model[20]);
        step();
        check_bus("R8 access unchanged", 1'b1, model[20]);

        // R9: each inactive chip select deselects
        for (int k = 0; k < 4; k++) begin
            set_ctl_rd(21);
            step();
            set_idle();
            if (k == 3) begin
                cpu_strobe_n = 1'b0; sel3_n = 1'b1;
            end else begin
                ctl_strobe_n = 1'b0;
                if (k == 0) sel1_n = 1'b1;
                if (k == 1) sel2 = 1'b0;
                if (k == 2) sel3_n = 1'b1;
            end
            step();
            set_idle();
            step();
            check_bus("R9 deselect", 1'b0, '0);
        end

        // R11 / R12: late deselect, quiet first cycle on reselect
        set_ctl_rd(22);
        step();
        set_deselect();
        step();
        check_bus("R11 still driving", 1'b1, model[22]);
        set_idle();
        step();
        check_bus("R11 released", 1'b0, '0);
        step();
        check_bus("R1 idle stays deselected", 1'b0, '0);
        set_ctl_rd(23);
        step();
        check_bus("R12 first cycle quiet", 1'b0, '0);
        set_idle();
        step();
        check_bus("R12 then driven", 1'b1, model[23]);
        set_ctl_rd(24);
        step();
        set_deselect();
        step();
        check_bus("R11 back-to-back old word", 1'b1, model[24]);
        set_ctl_rd(25);
        step();
        check_bus("R12 back-to-back gap", 1'b0, '0);
        set_idle();
        step();
        check_bus("R12 back-to-back new word", 1'b1, model[25]);

        // R10: bursts in both orders from every start offset
        for (int md = 0; md < 2; md++) begin
            for (int s = 0; s < 4; s++) begin
                lin_mode = md[0];
                set_ctl_rd(40 + s);
                step();
                for (int k = 0; k < 4; k++) begin
                    set_idle();
                    burst_adv_n = 1'b0;
                    step();
                    check_bus("R10 burst step", 1'b1,
                              model[40 + (md[0] ? ((s + k) % 4) : (s ^ k))]);
                end
                set_idle();
                step();
                check_bus("R10 burst wrap", 1'b1, model[40 + s]);
            end
        end
        lin_mode = 1'b1;

        // R13: asynchronous output enable
        set_ctl_rd(30);
        step();
        set_idle();
        step();
        out_en_n = 1'b1;
        #1;
        check_bus("R13 released without clock", 1'b0, '0);
        step();
        check_bus("R13 stays released", 1'b0, '0);
        out_en_n = 1'b0;
        #1;
        check_bus("R13 pipeline kept", 1'b1, model[30]);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule